// File: doc/BRIEF.md
# Operand Fetch and Address Sequencer

This block works behind the instruction decoder of a small 8-bit accumulator CPU with a 16-bit address space. The decoder hands it an opcode and an addressing-mode code on a start strobe. The block then reads the operand bytes that follow the opcode through a byte-wide memory read port, one byte per request. It steps its program counter past the whole instruction. It finishes with a one-cycle done pulse. With that pulse it presents either an immediate data byte or a 16-bit effective address, plus the program counter of the next instruction.

Five modes are handled. Inherent and no-offset indexed instructions occupy only the opcode byte. Immediate and direct instructions carry one operand byte. Extended instructions carry two. Direct and indexed addressing are confined to page zero: the upper address byte is forced to zero, and the block never reads it from memory.

Top module: `opfetch_seq`

## Requirements
- R1: While reset is high and in the cycle after it, `pc` equals the `PC_RESET` parameter, and every other output is zero: `busy`, `done`, `mem_rd`, `ea`, `imm`, `is_imm`, `no_opnd`, `done_mode` and `opcode_out`.
- R2: Mode code 0 (inherent) reads no memory. `done` rises in the cycle after the accepting edge, with `no_opnd`=1, `is_imm`=0, `ea`=0, `imm`=0, and `pc` advanced by 1.
- R3: Mode code 1 (immediate) reads one byte at `pc`+1. `done` rises with that byte on `imm`, `is_imm`=1, `ea`=0, and `pc` advanced by 2.
- R4: Mode code 2 (direct) reads one byte at `pc`+1. `done` rises with `ea` = {0x00, byte}, and `pc` advanced by 2.
- R5: Mode code 3 (extended) reads `pc`+1 and then `pc`+2. `done` rises with `ea` = {first byte, second byte}, and `pc` advanced by 3.
- R6: Mode code 4 (indexed, no offset) reads no memory. `done` rises in the cycle after the accepting edge with `ea` = {0x00, `index_reg`}, where `index_reg` is sampled at that edge, and `pc` advanced by 1.
- R7: A read request lasts one cycle, and `mem_rd` is low in the cycle that follows. The returned byte is taken one cycle after the request. `done` comes 1 cycle after the accepting edge for modes with no operand bytes, 3 cycles after for one operand byte, and 5 cycles after for two.
- R8: `start` is accepted only while `busy` is low. A `start` that arrives while `busy` is high produces no extra `done`. It does not change the result of the instruction in progress.
- R9: Every accepted instruction gives exactly one `done` pulse. With that pulse, `done_mode` carries the mode code and `opcode_out` carries the opcode that were sampled at acceptance. An instruction may be accepted in the same cycle as the previous `done`.
- R10: Mode codes 5, 6 and 7 behave as mode 0 (inherent), and `done_mode` reports 0 for them.
- R11: The program counter and the fetch address wrap modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a new instruction (honoured only while idle) |
| mode | input | 3 | Addressing-mode code (0 inherent, 1 immediate, 2 direct, 3 extended, 4 indexed) |
| opcode | input | 8 | Opcode of the instruction being started |
| index_reg | input | 8 | Current index register value |
| mem_addr | output | 16 | Read address for the operand byte |
| mem_rd | output | 1 | Read request, one cycle |
| mem_data | input | 8 | Read data, valid one cycle after the request |
| pc | output | 16 | Program counter; points past the instruction once done is high |
| ea | output | 16 | Effective address of the finished instruction |
| imm | output | 8 | Immediate byte of the finished instruction |
| is_imm | output | 1 | Finished instruction was immediate |
| no_opnd | output | 1 | Finished instruction was inherent |
| done_mode | output | 3 | Mode code of the finished instruction |
| opcode_out | output | 8 | Opcode of the finished instruction |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | An instruction is being fetched |

## Verification
The bench builds the block with `DW` = 8 and `PC_RESET` = 0xFFF0, so the program counter begins sixteen bytes below the top of memory. That start point puts three corner cases within a dozen instructions. An extended operand of 0xFFFF is fetched from 0xFFF6 and 0xFFF7. Later, an extended instruction placed at 0xFFFD reads its second byte from 0xFFFF, and the program counter then rolls over to 0x0000. A random mix of modes then runs from low memory, including back-to-back issues and `start` pulses held high while the block is busy.

// File: rtl/opfetch_pkg.sv
package opfetch_pkg;

  typedef enum logic [2:0] {
    AM_INH = 3'd0,
    AM_IMM = 3'd1,
    AM_DIR = 3'd2,
    AM_EXT = 3'd3,
    AM_IDX = 3'd4
  } amode_e;

  // Codes beyond the defined set fall back to inherent.
  function automatic amode_e norm_mode(input logic [2:0] code);
    if (code > 3'd4) return AM_INH;
    return amode_e'(code);
  endfunction

  // Bytes the instruction occupies, opcode included.
  function automatic logic [1:0] instr_len(input amode_e m);
    case (m)
      AM_IMM, AM_DIR: return 2'd2;
      AM_EXT:         return 2'd3;
      default:        return 2'd1;
    endcase
  endfunction

  // Bytes that must be read after the opcode.
  function automatic logic [1:0] operand_count(input amode_e m);
    case (m)
      AM_IMM, AM_DIR: return 2'd1;
      AM_EXT:         return 2'd2;
      default:        return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/opfetch_ctrl.sv
module opfetch_ctrl
  import opfetch_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [2:0] mode_in,
  output logic       busy,
  output logic       mem_rd,
  output logic [1:0] byte_idx,
  output logic       accept,
  output logic       capture,
  output logic       first_byte,
  output logic       finish,
  output amode_e     fin_mode
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_e;

  st_e        state_q;
  amode_e     mode_q;
  logic [1:0] need_q;
  logic [1:0] idx_q;
  amode_e     in_mode;
  logic [1:0] need_in;
  logic       last_byte;

  always_comb begin
    in_mode    = norm_mode(mode_in);
    need_in    = operand_count(in_mode);
    accept     = start && (state_q == S_IDLE);
    capture    = (state_q == S_WAIT);
    last_byte  = (idx_q == need_q - 2'd1);
    first_byte = capture && (idx_q == 2'd0);
    finish     = (accept && (need_in == 2'd0)) || (capture && last_byte);
    fin_mode   = accept ? in_mode : mode_q;
    busy       = (state_q != S_IDLE);
    mem_rd     = (state_q == S_REQ);
    byte_idx   = idx_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      mode_q  <= AM_INH;
      need_q  <= 2'd0;
      idx_q   <= 2'd0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (accept) begin
            mode_q <= in_mode;
            need_q <= need_in;
            idx_q  <= 2'd0;
            if (need_in != 2'd0) state_q <= S_REQ;
          end
        end
        S_REQ:  state_q <= S_WAIT;
        S_WAIT: begin
          if (last_byte) begin
            state_q <= S_IDLE;
          end else begin
            idx_q   <= idx_q + 2'd1;
            state_q <= S_REQ;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/opfetch_pc.sv
module opfetch_pc
  import opfetch_pkg::*;
#(
  parameter int unsigned        AW       = 16,
  parameter logic [AW-1:0]      PC_RESET = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          finish,
  input  amode_e        fin_mode,
  input  logic [1:0]    byte_idx,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] fetch_addr
);

  logic [AW-1:0] pc_q;

  // Operand byte k sits k+1 bytes past the opcode.
  function automatic logic [AW-1:0] operand_addr(input logic [AW-1:0] base,
                                                 input logic [1:0] k);
    return base + AW'(k) + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst)         pc_q <= PC_RESET;
    else if (finish) pc_q <= pc_q + AW'(instr_len(fin_mode));
  end

  assign pc         = pc_q;
  assign fetch_addr = operand_addr(pc_q, byte_idx);

endmodule

// File: rtl/opfetch_result.sv
module opfetch_result
  import opfetch_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic [DW-1:0] opcode_in,
  input  logic [DW-1:0] index_in,
  input  logic          first_byte,
  input  logic          finish,
  input  amode_e        fin_mode,
  input  logic [DW-1:0] mem_data,
  output logic [AW-1:0] ea,
  output logic [DW-1:0] imm,
  output logic          is_imm,
  output logic          no_opnd,
  output logic          done,
  output logic [2:0]    done_mode,
  output logic [DW-1:0] opcode_out
);

  logic [DW-1:0] b0_q;
  logic [DW-1:0] op_q;

  function automatic logic [AW-1:0] page_zero(input logic [DW-1:0] lo);
    return {{DW{1'b0}}, lo};
  endfunction

  function automatic logic [AW-1:0] form_ea(input amode_e m,
                                            input logic [DW-1:0] hi,
                                            input logic [DW-1:0] lo,
                                            input logic [DW-1:0] ix);
    case (m)
      AM_DIR:  return page_zero(lo);
      AM_EXT:  return {hi, lo};
      AM_IDX:  return page_zero(ix);
      default: return '0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      b0_q       <= '0;
      op_q       <= '0;
      ea         <= '0;
      imm        <= '0;
      is_imm     <= 1'b0;
      no_opnd    <= 1'b0;
      done       <= 1'b0;
      done_mode  <= 3'd0;
      opcode_out <= '0;
    end else begin
      done <= finish;
      if (first_byte) b0_q <= mem_data;
      if (accept)     op_q <= opcode_in;
      if (finish) begin
        ea         <= form_ea(fin_mode, b0_q, mem_data, index_in);
        imm        <= (fin_mode == AM_IMM) ? mem_data : '0;
        is_imm     <= (fin_mode == AM_IMM);
        no_opnd    <= (fin_mode == AM_INH);
        done_mode  <= fin_mode;
        opcode_out <= accept ? opcode_in : op_q;
      end
    end
  end

endmodule

// File: rtl/opfetch_seq.sv
module opfetch_seq
  import opfetch_pkg::*;
#(
  parameter int unsigned       DW       = 8,
  parameter logic [2*DW-1:0]   PC_RESET = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        mode,
  input  logic [DW-1:0]     opcode,
  input  logic [DW-1:0]     index_reg,
  output logic [2*DW-1:0]   mem_addr,
  output logic              mem_rd,
  input  logic [DW-1:0]     mem_data,
  output logic [2*DW-1:0]   pc,
  output logic [2*DW-1:0]   ea,
  output logic [DW-1:0]     imm,
  output logic              is_imm,
  output logic              no_opnd,
  output logic [2:0]        done_mode,
  output logic [DW-1:0]     opcode_out,
  output logic              done,
  output logic              busy
);

  localparam int unsigned AW = 2 * DW;

  // Internal events, named for the checker.
  logic       w_accept;
  logic       w_capture;
  logic       w_first;
  logic       w_finish;
  logic [1:0] w_idx;
  amode_e     w_fin_mode;

  opfetch_ctrl ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .mode_in    (mode),
    .busy       (busy),
    .mem_rd     (mem_rd),
    .byte_idx   (w_idx),
    .accept     (w_accept),
    .capture    (w_capture),
    .first_byte (w_first),
    .finish     (w_finish),
    .fin_mode   (w_fin_mode)
  );

  opfetch_pc #(.AW(AW), .PC_RESET(PC_RESET)) pc_i (
    .clk        (clk),
    .rst        (rst),
    .finish     (w_finish),
    .fin_mode   (w_fin_mode),
    .byte_idx   (w_idx),
    .pc         (pc),
    .fetch_addr (mem_addr)
  );

  opfetch_result #(.DW(DW)) res_i (
    .clk        (clk),
    .rst        (rst),
    .accept     (w_accept),
    .opcode_in  (opcode),
    .index_in   (index_reg),
    .first_byte (w_first),
    .finish     (w_finish),
    .fin_mode   (w_fin_mode),
    .mem_data   (mem_data),
    .ea         (ea),
    .imm        (imm),
    .is_imm     (is_imm),
    .no_opnd    (no_opnd),
    .done       (done),
    .done_mode  (done_mode),
    .opcode_out (opcode_out)
  );

endmodule

// File: rtl/opfetch_seq_chk.sv
module opfetch_seq_chk #(
  parameter int unsigned DW = 8,
  localparam int unsigned AW = 2 * DW
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          mem_rd,
  input logic [AW-1:0] pc,
  input logic [AW-1:0] ea,
  input logic          is_imm,
  input logic          no_opnd,
  input logic [2:0]    done_mode,
  input logic          done,
  input logic          w_capture
);

  p_idle_no_read_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_rd);

  p_read_gap_r7: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> (!mem_rd && w_capture));

  p_inh_step_r2: assert property (@(posedge clk) disable iff (rst)
    (done && done_mode == 3'd0) |-> (no_opnd && ea == '0 && pc == AW'($past(pc) + AW'(1))));

  p_imm_step_r3: assert property (@(posedge clk) disable iff (rst)
    (done && is_imm) |-> (done_mode == 3'd1 && ea == '0 && pc == AW'($past(pc) + AW'(2))));

  p_dir_page0_r4: assert property (@(posedge clk) disable iff (rst)
    (done && done_mode == 3'd2) |-> (ea[AW-1:DW] == '0 && pc == AW'($past(pc) + AW'(2))));

  p_ext_step_r5: assert property (@(posedge clk) disable iff (rst)
    (done && done_mode == 3'd3) |-> (pc == AW'($past(pc) + AW'(3))));

  p_idx_page0_r6: assert property (@(posedge clk) disable iff (rst)
    (done && done_mode == 3'd4) |-> (ea[AW-1:DW] == '0 && pc == AW'($past(pc) + AW'(1))));

  p_pc_hold_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(pc));

  p_start_taken_r8: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (done || busy));

  p_flags_excl_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> ($countones({is_imm, no_opnd}) <= 1));

  p_mode_range_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> (done_mode <= 3'd4));

endmodule

bind opfetch_seq opfetch_seq_chk #(.DW(DW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .busy      (busy),
  .mem_rd    (mem_rd),
  .pc        (pc),
  .ea        (ea),
  .is_imm    (is_imm),
  .no_opnd   (no_opnd),
  .done_mode (done_mode),
  .done      (done),
  .w_capture (w_capture)
);

// File: tb/opfetch_seq_tb_top.sv
module opfetch_seq_tb_top;

  localparam logic [15:0] START_PC = 16'hFFF0;

  typedef struct {
    logic [15:0] ea;
    logic [15:0] pc;
    logic [7:0]  imm;
    logic [7:0]  op;
    logic        is_imm;
    logic        no_opnd;
    logic [2:0]  mode;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [7:0]  opcode = 8'h00;
  logic [7:0]  index_reg = 8'h00;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  mem_data = 8'h00;
  logic [15:0] pc, ea;
  logic [7:0]  imm, opcode_out;
  logic        is_imm, no_opnd, done, busy;
  logic [2:0]  done_mode;

  int checks = 0;
  int fails  = 0;
  int ncyc   = 0;
  logic [15:0] model_pc = START_PC;
  logic [7:0]  ovr [int];
  exp_t        item_q [$];
  logic [15:0] addr_q [$];
  int          time_q [$];

  always #5 clk = ~clk;

  opfetch_seq #(.DW(8), .PC_RESET(START_PC)) dut_i (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .opcode(opcode),
    .index_reg(index_reg), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_data(mem_data), .pc(pc), .ea(ea), .imm(imm), .is_imm(is_imm),
    .no_opnd(no_opnd), .done_mode(done_mode), .opcode_out(opcode_out),
    .done(done), .busy(busy)
  );

  function automatic logic [7:0] rd_byte(input logic [15:0] a);
    if (ovr.exists(int'(a))) return ovr[int'(a)];
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  function automatic logic [2:0] eff_mode(input logic [2:0] m);
    return (m > 3'd4) ? 3'd0 : m;
  endfunction

  function automatic int latency(input logic [2:0] m);
    case (eff_mode(m))
      3'd1, 3'd2: return 3;
      3'd3:       return 5;
      default:    return 1;
    endcase
  endfunction

  function automatic string tag(input logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R10";
    endcase
  endfunction

  // Memory: data one cycle after the request.
  always @(posedge clk) if (mem_rd) mem_data <= rd_byte(mem_addr);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Driver: computes the expected result, pushes it, then drives start.
  task automatic issue(input logic [2:0] m, input logic [7:0] op,
                       input logic [7:0] ix, input int noise);
    exp_t e;
    logic [2:0]  em = eff_mode(m);
    logic [7:0]  b1 = rd_byte(model_pc + 16'd1);
    logic [7:0]  b2 = rd_byte(model_pc + 16'd2);
    e.mode = em; e.op = op; e.ea = 16'h0000; e.imm = 8'h00;
    e.is_imm = (em == 3'd1); e.no_opnd = (em == 3'd0);
    case (em)
      3'd1: begin e.imm = b1; addr_q.push_back(model_pc + 16'd1); e.pc = model_pc + 16'd2; end
      3'd2: begin e.ea = {8'h00, b1}; addr_q.push_back(model_pc + 16'd1); e.pc = model_pc + 16'd2; end
      3'd3: begin
        e.ea = {b1, b2};
        addr_q.push_back(model_pc + 16'd1);
        addr_q.push_back(model_pc + 16'd2);
        e.pc = model_pc + 16'd3;
      end
      3'd4: begin e.ea = {8'h00, ix}; e.pc = model_pc + 16'd1; end
      default: e.pc = model_pc + 16'd1;
    endcase
    model_pc = e.pc;
    item_q.push_back(e);
    while (busy) begin @(posedge clk); #1; end
    start = 1'b1; mode = m; opcode = op; index_reg = ix;
    @(posedge clk); #1;
    start = 1'b0; index_reg = ~ix;
    if (noise > 0) begin
      // R8: start held high while busy must be ignored
      start = 1'b1; mode = 3'd0; opcode = 8'hEE;
      repeat (noise) begin @(posedge clk); #1; end
      start = 1'b0;
    end
  endtask

  // Monitor: scoreboard comparison away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      ncyc++;
      if (start && !busy) time_q.push_back(ncyc + latency(mode));
      if (mem_rd) begin
        if (addr_q.size() == 0) chk(1'b0, "R7", "unexpected read", 32'(mem_addr), 0);
        else begin
          logic [15:0] ea_x;
          ea_x = addr_q.pop_front();
          chk(mem_addr == ea_x, "R7", "read address", 32'(mem_addr), 32'(ea_x));
        end
      end
      if (done) begin
        if (item_q.size() == 0) chk(1'b0, "R8", "extra done", 32'(opcode_out), 0);
        else begin
          exp_t e;
          int t;
          string r;
          e = item_q.pop_front();
          t = (time_q.size() != 0) ? time_q.pop_front() : -1;
          r = tag(e.mode);
          chk(ncyc == t, "R7", "done cycle", 32'(ncyc), 32'(t));
          chk(ea == e.ea, r, "ea", 32'(ea), 32'(e.ea));
          chk(pc == e.pc, r, "pc", 32'(pc), 32'(e.pc));
          chk(imm == e.imm, r, "imm", 32'(imm), 32'(e.imm));
          chk({is_imm, no_opnd} == {e.is_imm, e.no_opnd}, r, "flags",
              32'({is_imm, no_opnd}), 32'({e.is_imm, e.no_opnd}));
          chk(done_mode == e.mode, "R9", "done_mode", 32'(done_mode), 32'(e.mode));
          chk(opcode_out == e.op, "R9", "opcode_out", 32'(opcode_out), 32'(e.op));
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(pc == START_PC, "R1", "pc", 32'(pc), 32'(START_PC));
    chk({busy, done, mem_rd, is_imm, no_opnd} == 5'b0, "R1", "status",
        32'({busy, done, mem_rd, is_imm, no_opnd}), 0);
    chk(ea == 16'h0 && imm == 8'h0 && opcode_out == 8'h0 && done_mode == 3'd0,
        "R1", "data outputs", 32'({ea, imm}), 0);
    @(posedge clk); #1;

    ovr[16'hFFF2] = 8'h3C;
    ovr[16'hFFF4] = 8'hFF;
    ovr[16'hFFF6] = 8'hFF;
    ovr[16'hFFF7] = 8'hFF;
    issue(3'd0, 8'h4C, 8'h11, 0);   // R2 at FFF0
    issue(3'd1, 8'hA6, 8'h22, 0);   // R3 at FFF1
    issue(3'd2, 8'hB6, 8'h33, 0);   // R4 direct 0xFF at FFF3
    issue(3'd3, 8'hC6, 8'h44, 0);   // R5 extended 0xFFFF at FFF5
    issue(3'd4, 8'hF6, 8'h00, 0);   // R6 index 0x00 at FFF8
    issue(3'd4, 8'hF7, 8'h80, 0);   // R6 index 0x80
    issue(3'd5, 8'h01, 8'h00, 0);   // R10
    issue(3'd6, 8'h02, 8'h00, 0);   // R10
    issue(3'd7, 8'h03, 8'h00, 0);   // R10
    issue(3'd3, 8'hCE, 8'h00, 0);   // R11: reads FFFE, FFFF; pc wraps to 0000
    issue(3'd1, 8'hA1, 8'h00, 0);   // R11 after wrap
    issue(3'd3, 8'hC7, 8'h00, 3);   // R8 noise while busy
    issue(3'd1, 8'hA2, 8'h00, 1);   // R8 noise while busy
    for (int i = 0; i < 40; i++) begin
      issue(3'($urandom_range(0, 7)), 8'($urandom), 8'($urandom), 0);
    end
    repeat (8) @(posedge clk);
    // R9: one done per accepted instruction
    chk(item_q.size() == 0, "R9", "outstanding items", item_q.size(), 0);
    chk(addr_q.size() == 0, "R7", "outstanding reads", addr_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", item_q.size());
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule